// File: doc/BRIEF.md
# Nested priority interrupt controller

This block gathers a set of level-sensitive interrupt request lines and routes each one to one of two processor request outputs: a normal request line and a fast request line. Each source has a programmable priority, a mask bit and a route bit. The most urgent eligible source for each output is chosen by a tournament, and the result is latched. The winner's index and priority stay readable until software asks for a new arbitration.

Nesting is under software control. A handler reads the active priority and writes it to the shared threshold, so that only strictly more urgent requests remain eligible. It then writes the new-arbitration bit for its output. That write drops the request line at once, and a fresh result appears a fixed two cycles later. A more urgent request can then preempt the running handler while equal or lower ones wait.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset, both request outputs are low. Both active-number registers read the spurious code 0x80, both active-priority registers read 0x3F, the threshold reads 0x3F, and every source configuration word reads 0x7F (masked, priority 0x3F, normal route).
- R2: The configuration word of source i sits at address 0x80+i. Bits [5:0] hold the priority, bit 6 is the mask (1 = masked) and bit 7 is the route (1 = fast output). The word reads back as written. The threshold sits at address 0x01 in bits [5:0] and reads back as written.
- R3: Among eligible sources routed to one output, the lowest priority value wins. On equal priority, the lowest source index wins.
- R4: Starting from an idle output, a source input that goes high is sampled on the next rising edge, and the output rises on the second rising edge that sees it high.
- R5: While an output is high, its active number and priority do not change, even if a more urgent source arrives, until a new-arbitration write is made for that output.
- R6: Writing address 0x00 with bit 0 set (normal) or bit 1 set (fast) starts a new arbitration for that output. The output is low after the write edge and after the next edge, and shows a fresh result after the second edge. Each bit touches only its own output.
- R7: A source is eligible only if its priority value is strictly below the threshold. When the threshold is 0x3F, every priority is eligible.
- R8: A masked source never takes part in arbitration, whatever its priority.
- R9: The route bit selects the output. The normal output reports its winner at 0x02 (number) and 0x03 (priority), and the fast output at 0x04 and 0x05.
- R10: When no source is eligible for an output, that output is low, its number register reads 0x80 and its priority register reads 0x3F.
- R11: A source that rises in the same cycle as a new-arbitration write takes part in the fresh arbitration and can win it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| src_lvl | input | N | Level-sensitive source request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | IDX_W+1 | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | IDX_W+1 | Read address |
| rd_data | output | DW | Combinational read data |
| irq_o | output | 1 | Normal request output |
| fiq_o | output | 1 | Fast request output |

## Verification
The two functions that can fall in the same cycle are a new-arbitration write and a new source going high. To provoke this, the bench raises a more urgent line on the same falling edge that presents the control write. It then checks that the output is low for two cycles and comes back reporting the new source rather than the one served before. A second overlap writes both new-arbitration bits at once, and the bench checks that each output re-arbitrates on its own using only sources routed to it.

// File: rtl/nic_pkg.sv
`timescale 1ns/1ps
package nic_pkg;

   // Global register selectors (low address bits when the top address bit is 0)
   typedef enum logic [2:0] {
      REG_CTRL     = 3'd0,
      REG_THRESH   = 3'd1,
      REG_IRQ_NUM  = 3'd2,
      REG_IRQ_PRIO = 3'd3,
      REG_FIQ_NUM  = 3'd4,
      REG_FIQ_PRIO = 3'd5
   } glob_reg_e;

   localparam int OUT_IRQ = 0;
   localparam int OUT_FIQ = 1;
   localparam int NUM_OUT = 2;

endpackage

// File: rtl/nic_src_cfg.sv
`timescale 1ns/1ps
module nic_src_cfg #(
   parameter int N      = 128,
   parameter int PRIO_W = 6,
   parameter int IDX_W  = 7,
   parameter int DW     = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [IDX_W-1:0]    cfg_idx,
   input  logic [DW-1:0]       cfg_wdata,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [DW-1:0]       rd_cfg,
   input  logic [N-1:0]        src_lvl,
   input  logic [PRIO_W-1:0]   thresh,
   output logic [N*PRIO_W-1:0] prio_flat,
   output logic [N-1:0]        elig_irq,
   output logic [N-1:0]        elig_fiq
);

   localparam int MASK_BIT  = PRIO_W;
   localparam int ROUTE_BIT = PRIO_W + 1;

   logic            thr_open;
   logic [DW-1:0]   cfg_word [N];

   assign thr_open = (thresh == {PRIO_W{1'b1}});

   for (genvar i = 0; i < N; i++) begin : g_src
      logic [PRIO_W-1:0] prio_q;
      logic              mask_q;
      logic              route_q;
      logic              live;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_q  <= '1;
            mask_q  <= 1'b1;
            route_q <= 1'b0;
         end else if (cfg_we && (cfg_idx == IDX_W'(i))) begin
            prio_q  <= cfg_wdata[PRIO_W-1:0];
            mask_q  <= cfg_wdata[MASK_BIT];
            route_q <= cfg_wdata[ROUTE_BIT];
         end
      end

      assign live = src_lvl[i] && !mask_q && (thr_open || (prio_q < thresh));
      assign elig_irq[i] = live && !route_q;
      assign elig_fiq[i] = live && route_q;
      assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q;
      assign cfg_word[i] = DW'({route_q, mask_q, prio_q});
   end

   always_comb begin
      rd_cfg = '0;
      for (int i = 0; i < N; i++) begin
         if (rd_idx == IDX_W'(i)) rd_cfg = cfg_word[i];
      end
   end

endmodule

// File: rtl/nic_arb_tree.sv
`timescale 1ns/1ps
module nic_arb_tree #(
   parameter int N      = 128,
   parameter int PRIO_W = 6,
   parameter int IDX_W  = 7
) (
   input  logic [N-1:0]        elig_i,
   input  logic [N*PRIO_W-1:0] prio_i,
   output logic                win_valid,
   output logic [IDX_W-1:0]    win_idx,
   output logic [PRIO_W-1:0]   win_prio
);

   localparam int P = 1 << IDX_W;

   for (genvar l = 0; l <= IDX_W; l++) begin : g_lvl
      localparam int W = P >> l;
      logic [W-1:0]        v;
      logic [W*PRIO_W-1:0] p;
      logic [W*IDX_W-1:0]  x;

      if (l == 0) begin : g_leaf
         for (genvar i = 0; i < P; i++) begin : g_in
            if (i < N) begin : g_real
               assign v[i] = elig_i[i];
               assign p[i*PRIO_W +: PRIO_W] = prio_i[i*PRIO_W +: PRIO_W];
            end else begin : g_pad
               assign v[i] = 1'b0;
               assign p[i*PRIO_W +: PRIO_W] = '1;
            end
            assign x[i*IDX_W +: IDX_W] = IDX_W'(i);
         end
      end else begin : g_merge
         for (genvar k = 0; k < W; k++) begin : g_pair
            logic                lv, rv, take_l;
            logic [PRIO_W-1:0]   lp, rp;
            assign lv = g_lvl[l-1].v[2*k];
            assign rv = g_lvl[l-1].v[2*k+1];
            assign lp = g_lvl[l-1].p[(2*k)*PRIO_W +: PRIO_W];
            assign rp = g_lvl[l-1].p[(2*k+1)*PRIO_W +: PRIO_W];
            // left half carries the lower indices, so it keeps ties
            assign take_l = lv && (!rv || (lp <= rp));
            assign v[k] = lv || rv;
            assign p[k*PRIO_W +: PRIO_W] = take_l ? lp : rp;
            assign x[k*IDX_W +: IDX_W] = take_l ? g_lvl[l-1].x[(2*k)*IDX_W +: IDX_W]
                                                : g_lvl[l-1].x[(2*k+1)*IDX_W +: IDX_W];
         end
      end
   end

   assign win_valid = g_lvl[IDX_W].v[0];
   assign win_prio  = g_lvl[IDX_W].p[PRIO_W-1:0];
   assign win_idx   = g_lvl[IDX_W].x[IDX_W-1:0];

endmodule

// File: rtl/nic_out_ctl.sv
`timescale 1ns/1ps
module nic_out_ctl #(
   parameter int N      = 128,
   parameter int PRIO_W = 6,
   parameter int IDX_W  = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        elig_i,
   input  logic [N*PRIO_W-1:0] prio_i,
   input  logic                agree_i,
   output logic                line_o,
   output logic [IDX_W:0]      act_num,
   output logic [PRIO_W-1:0]   act_prio
);

   localparam logic [IDX_W:0] SPUR = {1'b1, {IDX_W{1'b0}}};

   logic [N-1:0]      elig_q;
   logic              win_valid;
   logic [IDX_W-1:0]  win_idx;
   logic [PRIO_W-1:0] win_prio;
   logic              held_q;
   logic [IDX_W:0]    num_q;
   logic [PRIO_W-1:0] prio_q;

   // snapshot stage: an agreement write flushes it so the next result is fresh
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       elig_q <= '0;
      else if (agree_i) elig_q <= '0;
      else              elig_q <= elig_i;
   end

   nic_arb_tree #(.N(N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_tree (
      .elig_i    (elig_q),
      .prio_i    (prio_i),
      .win_valid (win_valid),
      .win_idx   (win_idx),
      .win_prio  (win_prio)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         num_q  <= SPUR;
         prio_q <= '1;
      end else if (agree_i) begin
         held_q <= 1'b0;
         num_q  <= SPUR;
         prio_q <= '1;
      end else if (!held_q) begin
         held_q <= win_valid;
         num_q  <= win_valid ? {1'b0, win_idx} : SPUR;
         prio_q <= win_valid ? win_prio : '1;
      end
   end

   assign line_o   = held_q;
   assign act_num  = num_q;
   assign act_prio = prio_q;

   // R6
   agree_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      agree_i |=> !held_q ##1 !held_q);

   // R5
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && !agree_i) |=> (held_q && $stable(num_q) && $stable(prio_q)));

   // R10
   held_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held_q |-> !num_q[IDX_W]);

   // R3
   tree_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|elig_q) |-> win_valid);

endmodule

// File: rtl/nested_irq_ctrl.sv
`timescale 1ns/1ps
module nested_irq_ctrl #(
   parameter int N      = 128,
   parameter int PRIO_W = 6,
   localparam int IDX_W = $clog2(N),
   localparam int AW    = IDX_W + 1,
   localparam int DW    = ((PRIO_W + 2) > (IDX_W + 1)) ? (PRIO_W + 2) : (IDX_W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  src_lvl,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic          irq_o,
   output logic          fiq_o
);
   import nic_pkg::*;

   localparam int GW = AW - 1;

   if (N < 8) begin : g_bad_n
      $error("nested_irq_ctrl: N must be at least 8");
   end
   if (PRIO_W < 2) begin : g_bad_prio
      $error("nested_irq_ctrl: PRIO_W must be at least 2");
   end

   logic                wr_glob, wr_src;
   logic [PRIO_W-1:0]   thresh_q;
   logic [DW-1:0]       cfg_rd;
   logic [N*PRIO_W-1:0] prio_flat;
   logic [N-1:0]        elig_v [NUM_OUT];
   logic [NUM_OUT-1:0]  agree;
   logic [NUM_OUT-1:0]  line;
   logic [IDX_W:0]      num_v  [NUM_OUT];
   logic [PRIO_W-1:0]   prio_v [NUM_OUT];

   assign wr_src  = wr_en &&  wr_addr[AW-1];
   assign wr_glob = wr_en && !wr_addr[AW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         thresh_q <= '1;
      else if (wr_glob && (wr_addr[GW-1:0] == GW'(REG_THRESH)))
         thresh_q <= wr_data[PRIO_W-1:0];
   end

   nic_src_cfg #(.N(N), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .DW(DW)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (wr_src),
      .cfg_idx   (wr_addr[IDX_W-1:0]),
      .cfg_wdata (wr_data),
      .rd_idx    (rd_addr[IDX_W-1:0]),
      .rd_cfg    (cfg_rd),
      .src_lvl   (src_lvl),
      .thresh    (thresh_q),
      .prio_flat (prio_flat),
      .elig_irq  (elig_v[OUT_IRQ]),
      .elig_fiq  (elig_v[OUT_FIQ])
   );

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      assign agree[o] = wr_glob && (wr_addr[GW-1:0] == GW'(REG_CTRL)) && wr_data[o];

      nic_out_ctl #(.N(N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_out (
         .clk      (clk),
         .rst_n    (rst_n),
         .elig_i   (elig_v[o]),
         .prio_i   (prio_flat),
         .agree_i  (agree[o]),
         .line_o   (line[o]),
         .act_num  (num_v[o]),
         .act_prio (prio_v[o])
      );
   end

   assign irq_o = line[OUT_IRQ];
   assign fiq_o = line[OUT_FIQ];

   always_comb begin
      rd_data = '0;
      if (rd_addr[AW-1]) begin
         rd_data = cfg_rd;
      end else begin
         case (rd_addr[GW-1:0])
            GW'(REG_THRESH):   rd_data = DW'(thresh_q);
            GW'(REG_IRQ_NUM):  rd_data = DW'(num_v[OUT_IRQ]);
            GW'(REG_IRQ_PRIO): rd_data = DW'(prio_v[OUT_IRQ]);
            GW'(REG_FIQ_NUM):  rd_data = DW'(num_v[OUT_FIQ]);
            GW'(REG_FIQ_PRIO): rd_data = DW'(prio_v[OUT_FIQ]);
            default:           rd_data = '0;
         endcase
      end
   end

   // R9
   route_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && fiq_o) |-> (num_v[OUT_IRQ] != num_v[OUT_FIQ]) || $past(wr_src));

endmodule

// File: tb/nested_irq_ctrl_test.sv
`timescale 1ns/1ps
module nested_irq_ctrl_test;

   localparam int N = 128;
   localparam int PRIO_W = 6;
   localparam int AW = 8;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_lvl = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          irq_o, fiq_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   nested_irq_ctrl #(.N(N), .PRIO_W(PRIO_W)) uut (
      .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .irq_o(irq_o), .fiq_o(fiq_o)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic chk_reg(input string req, input string what, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      logic [DW-1:0] d;
      rd(a, d);
      chk(req, what, d, exp);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cfg(input int idx, input logic [5:0] prio, input logic msk, input logic route);
      wr(8'h80 | AW'(idx), {route, msk, prio});
   endtask

   task automatic do_reset();
      rst_n = 1'b0; src_lvl = '0; wr_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "irq_o", irq_o, 0);
      chk("R1", "fiq_o", fiq_o, 0);
      chk_reg("R1", "irq num", 8'h02, 8'h80);
      chk_reg("R1", "irq prio", 8'h03, 8'h3F);
      chk_reg("R1", "fiq num", 8'h04, 8'h80);
      chk_reg("R1", "fiq prio", 8'h05, 8'h3F);
      chk_reg("R1", "threshold", 8'h01, 8'h3F);
      chk_reg("R1", "cfg 5", 8'h85, 8'h7F);
      chk_reg("R1", "cfg 127", 8'hFF, 8'h7F);
   endtask

   task automatic t_cfg_rw();
      do_reset();
      cfg(7, 6'h15, 1'b0, 1'b1);
      chk_reg("R2", "cfg 7", 8'h87, 8'h95);
      chk_reg("R2", "cfg 8 untouched", 8'h88, 8'h7F);
      wr(8'h01, 8'h22);
      chk_reg("R2", "threshold", 8'h01, 8'h22);
   endtask

   task automatic t_latency();
      do_reset();
      cfg(5, 6'd10, 1'b0, 1'b0);
      src_lvl[5] = 1'b1;
      step();
      chk("R4", "irq after 1 edge", irq_o, 0);
      step();
      chk("R4", "irq after 2 edges", irq_o, 1);
      chk("R9", "fiq stays low", fiq_o, 0);
      chk_reg("R9", "irq num", 8'h02, 8'd5);
      chk_reg("R9", "irq prio", 8'h03, 8'd10);
   endtask

   task automatic t_order();
      do_reset();
      cfg(9, 6'd4, 1'b0, 1'b0);
      cfg(20, 6'd4, 1'b0, 1'b0);
      cfg(3, 6'd7, 1'b0, 1'b0);
      cfg(1, 6'd0, 1'b0, 1'b0);
      src_lvl[9] = 1'b1; src_lvl[20] = 1'b1; src_lvl[3] = 1'b1;
      step(); step();
      chk("R3", "irq up", irq_o, 1);
      chk_reg("R3", "tie to lowest index", 8'h02, 8'd9);
      src_lvl[1] = 1'b1;
      repeat (4) step();
      chk("R5", "irq held", irq_o, 1);
      chk_reg("R5", "num stable", 8'h02, 8'd9);
      chk_reg("R5", "prio stable", 8'h03, 8'd4);
      wr(8'h00, 8'h01);
      chk("R6", "irq low after write edge", irq_o, 0);
      step();
      chk("R6", "irq low next edge", irq_o, 0);
      step();
      chk("R6", "irq back after 2 edges", irq_o, 1);
      chk_reg("R3", "most urgent wins", 8'h02, 8'd1);
      chk_reg("R3", "its priority", 8'h03, 8'd0);
   endtask

   task automatic t_nest();
      do_reset();
      cfg(30, 6'd20, 1'b0, 1'b0);
      cfg(31, 6'd25, 1'b0, 1'b0);
      cfg(32, 6'd12, 1'b0, 1'b0);
      src_lvl[30] = 1'b1; src_lvl[31] = 1'b1;
      step(); step();
      chk_reg("R3", "first served", 8'h02, 8'd30);
      wr(8'h01, 8'd20);
      wr(8'h00, 8'h01);
      step(); step(); step();
      chk("R7", "equal and lower blocked", irq_o, 0);
      chk_reg("R10", "spurious number", 8'h02, 8'h80);
      chk_reg("R10", "spurious prio", 8'h03, 8'h3F);
      src_lvl[32] = 1'b1;
      step(); step();
      chk("R7", "higher preempts", irq_o, 1);
      chk_reg("R7", "preempting number", 8'h02, 8'd32);
      chk_reg("R7", "preempting prio", 8'h03, 8'd12);
   endtask

   task automatic t_open();
      do_reset();
      cfg(70, 6'd63, 1'b0, 1'b0);
      src_lvl[70] = 1'b1;
      step(); step();
      chk("R7", "all-ones threshold admits 63", irq_o, 1);
      chk_reg("R7", "number", 8'h02, 8'd70);
      wr(8'h01, 8'd62);
      wr(8'h00, 8'h01);
      step(); step();
      chk("R7", "threshold 62 blocks 63", irq_o, 0);
      chk_reg("R10", "spurious", 8'h02, 8'h80);
   endtask

   task automatic t_mask();
      do_reset();
      cfg(12, 6'd0, 1'b1, 1'b0);
      cfg(13, 6'd5, 1'b0, 1'b0);
      src_lvl[12] = 1'b1;
      step(); step(); step();
      chk("R8", "masked source ignored", irq_o, 0);
      chk_reg("R8", "number spurious", 8'h02, 8'h80);
      src_lvl[13] = 1'b1;
      step(); step();
      chk("R8", "unmasked delivered", irq_o, 1);
      chk_reg("R8", "masked prio 0 loses", 8'h02, 8'd13);
   endtask

   task automatic t_route();
      do_reset();
      cfg(40, 6'd5, 1'b0, 1'b1);
      cfg(41, 6'd9, 1'b0, 1'b0);
      cfg(42, 6'd1, 1'b0, 1'b1);
      cfg(43, 6'd1, 1'b0, 1'b0);
      src_lvl[40] = 1'b1; src_lvl[41] = 1'b1;
      step(); step();
      chk("R9", "fiq up", fiq_o, 1);
      chk("R9", "irq up", irq_o, 1);
      chk_reg("R9", "fiq num", 8'h04, 8'd40);
      chk_reg("R9", "fiq prio", 8'h05, 8'd5);
      chk_reg("R9", "irq num", 8'h02, 8'd41);
      chk_reg("R9", "irq prio", 8'h03, 8'd9);
      src_lvl[42] = 1'b1; src_lvl[43] = 1'b1;
      wr(8'h00, 8'h01);
      chk("R6", "irq dropped", irq_o, 0);
      chk("R6", "fiq untouched", fiq_o, 1);
      step(); step();
      chk("R6", "irq re-arbitrated", irq_o, 1);
      chk_reg("R6", "irq new num", 8'h02, 8'd43);
      chk_reg("R6", "fiq num kept", 8'h04, 8'd40);
      wr(8'h00, 8'h03);
      chk("R6", "both dropped irq", irq_o, 0);
      chk("R6", "both dropped fiq", fiq_o, 0);
      step(); step();
      chk("R6", "fiq back", fiq_o, 1);
      chk_reg("R9", "fiq new num", 8'h04, 8'd42);
      chk_reg("R9", "irq num", 8'h02, 8'd43);
   endtask

   task automatic t_same();
      do_reset();
      cfg(50, 6'd30, 1'b0, 1'b0);
      cfg(51, 6'd10, 1'b0, 1'b0);
      src_lvl[50] = 1'b1;
      step(); step();
      chk_reg("R11", "old winner", 8'h02, 8'd50);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'h00; wr_data = 8'h01; src_lvl[51] = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R11", "irq low after write", irq_o, 0);
      step();
      chk("R11", "irq low next", irq_o, 0);
      step();
      chk("R11", "irq back", irq_o, 1);
      chk_reg("R11", "new source wins", 8'h02, 8'd51);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_cfg_rw();
      t_latency();
      t_order();
      t_nest();
      t_open();
      t_mask();
      t_route();
      t_same();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule